// File: doc/BRIEF.md
# Bridge Function Configuration Register Bank

This block holds the byte-wide configuration registers of a bridge function (function 0) in a multi-function device. A simple port carries a function number, a byte offset, write data and a write strobe. The block applies a separate write policy to each defined offset. Depending on the offset, that policy is a plain mask, bits that are hardwired to one, write-one-to-clear status, or a lock bit that cannot be cleared once set.

From these registers the block decodes three values: the base address of the power-management I/O window, the enable for that window, and the window's interrupt line. It raises a one-cycle system-management interrupt request whenever a write to the firmware control byte leaves both the lock bit and the write-enable bit set.

The block also holds the function-disable byte for the sibling functions 1 to 7. An access to a disabled function reads all ones and its writes are dropped. An access to an enabled sibling passes the write through as a strobe and returns that sibling's read data.

Top module: `lpc_cfg_bank`

## Requirements
- R1: After reset, function 0 reads as follows:
  - offsets 0x00 to 0x03 read the vendor and device identifiers, low byte first;
  - offset 0x04 reads 0x0F, offset 0x07 reads 0x02 and offset 0x40 reads 0x01;
  - offsets 0x41, 0x44, 0x4E and 0xF2 read 0x00.
  The decoded outputs after reset are base 0, decode disabled, interrupt 9, and no SMI request.
- R2: Offset 0x04 (command) stores only data bit 6. Bits 3:0 of offset 0x04 always read as 1 and all other bits read as 0.
- R3: Offset 0x07 (status high) is write-one-to-clear over mask 0xF9. Bits outside that mask keep their value, so its reset bit 1 survives any write.
- R4: The power-management base is {offset 0x41, offset 0x40 bit 7, seven zero bits}. Offset 0x40 bit 0 always reads 1, and its other bits read 0.
- R5: Offset 0x44 keeps only the bits in mask 0x17. Bit 4 drives the decode enable. With select bits 2:0 below 3 the interrupt line is 9 plus the select; any other select gives 9.
- R6: In offset 0x4E, bit 1 is the lock. Once bit 1 is 1 it stays 1 until reset, and only bit 0 (write enable) can still change. Bits 7:2 always read 0.
- R7: A write to offset 0x4E that leaves bits 1 and 0 both set raises smi_req for exactly the one following cycle. No other write raises it.
- R8: Offset 0xF2 keeps only the bits in mask 0xFE. Bit n disables function n: reads of that function return 0xFF and writes to it produce no peer_wr.
- R9: For an enabled function other than 0, cfg_rdata equals peer_rdata, and a write asserts peer_wr in the same cycle.
- R10: Writes to function 0 offsets without defined handling are ignored, and those offsets keep reading their reset value.
- R11: A synchronous active-high reset returns every register, including a set lock, to its reset value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_func | input | 3 | Function number of the access |
| cfg_addr | input | 8 | Byte offset of the access |
| cfg_wdata | input | 8 | Write data |
| cfg_wr | input | 1 | Write strobe, one byte per cycle |
| cfg_rdata | output | 8 | Read data, combinational from cfg_func and cfg_addr |
| peer_rdata | input | 8 | Read data from the addressed sibling function |
| peer_wr | output | 1 | Write strobe passed to an enabled sibling function |
| pm_base | output | 16 | Decoded power-management I/O base |
| pm_decode_en | output | 1 | Power-management decode enable |
| pm_irq | output | 4 | Power-management interrupt line number |
| smi_req | output | 1 | One-cycle system-management interrupt request |

## Verification
The main functions are exercised with all-ones and all-zeros data, which shows each offset's mask separately from its hardwired and sticky bits. Interrupt selects 0, 1, 2 and 3 through 7 separate the offset mapping from the fallback value of 9.

The firmware control byte is exercised with the sequence enable-only, lock-and-enable, clear-all, then enable-again. This sequence separates a lock that sticks from one that can be cleared, and shows an SMI raised by the final state from one raised by any write.

Sibling accesses are made before and after setting the disable byte, which shows both the pass-through path and the all-ones path. A reset applied after the lock is set confirms that the lock clears.

// File: rtl/lpc_cfg_bank.sv
module lpc_cfg_bank #(
  parameter logic [15:0] VENDOR_ID   = 16'h1A2B,
  parameter logic [15:0] DEVICE_ID   = 16'h3C4D,
  parameter int          PM_IRQ_BASE = 9
) (
  input  logic        clk,
  input  logic        rst,
  input  logic [2:0]  cfg_func,
  input  logic [7:0]  cfg_addr,
  input  logic [7:0]  cfg_wdata,
  input  logic        cfg_wr,
  output logic [7:0]  cfg_rdata,
  input  logic [7:0]  peer_rdata,
  output logic        peer_wr,
  output logic [15:0] pm_base,
  output logic        pm_decode_en,
  output logic [3:0]  pm_irq,
  output logic        smi_req
);
  localparam logic [7:0] OFS_CMD   = 8'h04;
  localparam logic [7:0] OFS_STSH  = 8'h07;
  localparam logic [7:0] OFS_BARL  = 8'h40;
  localparam logic [7:0] OFS_BARH  = 8'h41;
  localparam logic [7:0] OFS_PMCTL = 8'h44;
  localparam logic [7:0] OFS_FWCTL = 8'h4E;
  localparam logic [7:0] OFS_FDIS  = 8'hF2;
  localparam logic [7:0] STSH_W1C  = 8'hF9;
  localparam logic [7:0] PMCTL_MSK = 8'h17;
  localparam logic [7:0] FDIS_MSK  = 8'hFE;
  localparam logic [7:0] STSH_RST  = 8'h02;
  localparam logic [3:0] IRQ_BASE  = 4'(PM_IRQ_BASE);

  logic       cmd_q;
  logic [7:0] stsh_q;
  logic       barl_q;
  logic [7:0] barh_q;
  logic [7:0] pmctl_q;
  logic [1:0] fw_q;
  logic [7:0] fdis_q;
  logic       smi_q;
  logic [7:0] rd0;
  logic [1:0] fw_nxt;

  wire own_wr = cfg_wr && (cfg_func == 3'd0);
  wire fw_hit = own_wr && (cfg_addr == OFS_FWCTL);

  assign fw_nxt  = fw_q[1] ? {1'b1, cfg_wdata[0]} : cfg_wdata[1:0];
  assign peer_wr = cfg_wr && (cfg_func != 3'd0) && !fdis_q[cfg_func];

  always_ff @(posedge clk) begin
    if (rst) begin
      cmd_q   <= 1'b0;
      stsh_q  <= STSH_RST;
      barl_q  <= 1'b0;
      barh_q  <= 8'h00;
      pmctl_q <= 8'h00;
      fw_q    <= 2'b00;
      fdis_q  <= 8'h00;
      smi_q   <= 1'b0;
    end else begin
      smi_q <= fw_hit && (fw_nxt == 2'b11);
      if (own_wr) begin
        case (cfg_addr)
          OFS_CMD:   cmd_q   <= cfg_wdata[6];
          OFS_STSH:  stsh_q  <= stsh_q & ~(cfg_wdata & STSH_W1C);
          OFS_BARL:  barl_q  <= cfg_wdata[7];
          OFS_BARH:  barh_q  <= cfg_wdata;
          OFS_PMCTL: pmctl_q <= cfg_wdata & PMCTL_MSK;
          OFS_FWCTL: fw_q    <= fw_nxt;
          OFS_FDIS:  fdis_q  <= cfg_wdata & FDIS_MSK;
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    case (cfg_addr)
      8'h00:     rd0 = VENDOR_ID[7:0];
      8'h01:     rd0 = VENDOR_ID[15:8];
      8'h02:     rd0 = DEVICE_ID[7:0];
      8'h03:     rd0 = DEVICE_ID[15:8];
      OFS_CMD:   rd0 = {1'b0, cmd_q, 2'b00, 4'hF};
      OFS_STSH:  rd0 = stsh_q;
      OFS_BARL:  rd0 = {barl_q, 6'b0, 1'b1};
      OFS_BARH:  rd0 = barh_q;
      OFS_PMCTL: rd0 = pmctl_q;
      OFS_FWCTL: rd0 = {6'b0, fw_q};
      OFS_FDIS:  rd0 = fdis_q;
      default:   rd0 = 8'h00;
    endcase
  end

  assign cfg_rdata    = (cfg_func == 3'd0) ? rd0 :
                        fdis_q[cfg_func]   ? 8'hFF : peer_rdata;
  assign pm_base      = {barh_q, barl_q, 7'b0};
  assign pm_decode_en = pmctl_q[4];
  assign pm_irq       = (pmctl_q[2:0] < 3'd3) ? IRQ_BASE + {1'b0, pmctl_q[2:0]} : IRQ_BASE;
  assign smi_req      = smi_q;
endmodule

// File: rtl/lpc_cfg_bank_chk.sv
module lpc_cfg_bank_chk (
  input logic       clk,
  input logic       rst,
  input logic [2:0] cfg_func,
  input logic [7:0] cfg_addr,
  input logic       cfg_wr,
  input logic [7:0] cfg_rdata,
  input logic       peer_wr,
  input logic [3:0] pm_irq,
  input logic       smi_req,
  input logic       lock_bit,
  input logic [7:0] dis_bits
);
  p_cmd_low_r2: assert property (@(posedge clk) disable iff (rst)
    (cfg_func == 3'd0 && cfg_addr == 8'h04) |-> cfg_rdata[3:0] == 4'hF);

  p_bar_bit0_r4: assert property (@(posedge clk) disable iff (rst)
    (cfg_func == 3'd0 && cfg_addr == 8'h40) |-> cfg_rdata[0]);

  p_irq_range_r5: assert property (@(posedge clk) disable iff (rst)
    pm_irq inside {4'd9, 4'd10, 4'd11});

  p_lock_sticky_r6: assert property (@(posedge clk) disable iff (rst)
    lock_bit |=> lock_bit);

  p_smi_cause_r7: assert property (@(posedge clk) disable iff (rst)
    smi_req |-> $past(cfg_wr && cfg_func == 3'd0 && cfg_addr == 8'h4E));

  p_smi_locked_r7: assert property (@(posedge clk) disable iff (rst)
    smi_req |-> lock_bit);

  p_dis_block_r8: assert property (@(posedge clk) disable iff (rst)
    (cfg_func != 3'd0 && dis_bits[cfg_func]) |-> (cfg_rdata == 8'hFF && !peer_wr));

  p_peer_own_r9: assert property (@(posedge clk) disable iff (rst)
    peer_wr |-> (cfg_wr && cfg_func != 3'd0));
endmodule

bind lpc_cfg_bank lpc_cfg_bank_chk u_chk (
  .clk(clk), .rst(rst), .cfg_func(cfg_func), .cfg_addr(cfg_addr),
  .cfg_wr(cfg_wr), .cfg_rdata(cfg_rdata), .peer_wr(peer_wr),
  .pm_irq(pm_irq), .smi_req(smi_req), .lock_bit(fw_q[1]), .dis_bits(fdis_q)
);

// File: tb/lpc_cfg_bank_test.sv
module lpc_cfg_bank_test;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [2:0]  cfg_func = '0;
  logic [7:0]  cfg_addr = '0;
  logic [7:0]  cfg_wdata = '0;
  logic        cfg_wr = 1'b0;
  logic [7:0]  cfg_rdata;
  logic [7:0]  peer_rdata = 8'h5A;
  logic        peer_wr;
  logic [15:0] pm_base;
  logic        pm_decode_en;
  logic [3:0]  pm_irq;
  logic        smi_req;

  int checks = 0;
  int failures = 0;
  logic last_smi, last_peer;

  always #10 clk = ~clk;

  lpc_cfg_bank uut (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] f, input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    cfg_func = f; cfg_addr = a; cfg_wdata = d; cfg_wr = 1'b1;
    #1 last_peer = peer_wr;
    @(negedge clk);
    cfg_wr = 1'b0;
    last_smi = smi_req;
  endtask

  task automatic rd(input logic [2:0] f, input logic [7:0] a, output logic [7:0] d);
    @(negedge clk);
    cfg_func = f; cfg_addr = a;
    #1 d = cfg_rdata;
  endtask

  task automatic rchk(input string req, input logic [2:0] f, input logic [7:0] a, input logic [7:0] exp);
    logic [7:0] d;
    rd(f, a, d);
    chk(req, {24'b0, d}, {24'b0, exp});
  endtask

  task automatic t_reset_state(input string req);
    rchk(req, 0, 8'h00, 8'h2B); rchk(req, 0, 8'h01, 8'h1A);
    rchk(req, 0, 8'h02, 8'h4D); rchk(req, 0, 8'h03, 8'h3C);
    rchk(req, 0, 8'h04, 8'h0F); rchk(req, 0, 8'h07, 8'h02);
    rchk(req, 0, 8'h40, 8'h01); rchk(req, 0, 8'h41, 8'h00);
    rchk(req, 0, 8'h44, 8'h00); rchk(req, 0, 8'h4E, 8'h00);
    rchk(req, 0, 8'hF2, 8'h00);
    chk(req, {16'b0, pm_base}, 32'h0);
    chk(req, {31'b0, pm_decode_en}, 32'h0);
    chk(req, {28'b0, pm_irq}, 32'd9);
    chk(req, {31'b0, smi_req}, 32'h0);
  endtask

  task automatic t_command;
    wr(0, 8'h04, 8'hFF); rchk("R2", 0, 8'h04, 8'h4F);
    wr(0, 8'h04, 8'h00); rchk("R2", 0, 8'h04, 8'h0F);
  endtask

  task automatic t_status;
    wr(0, 8'h07, 8'hFF); rchk("R3", 0, 8'h07, 8'h02);
    wr(0, 8'h07, 8'h00); rchk("R3", 0, 8'h07, 8'h02);
  endtask

  task automatic t_pm_base;
    wr(0, 8'h40, 8'hFE); rchk("R4", 0, 8'h40, 8'h81);
    wr(0, 8'h41, 8'hAB);
    chk("R4", {16'b0, pm_base}, 32'hAB80);
    wr(0, 8'h40, 8'h00); rchk("R4", 0, 8'h40, 8'h01);
    chk("R4", {16'b0, pm_base}, 32'hAB00);
  endtask

  task automatic t_pm_ctl;
    wr(0, 8'h44, 8'hFF); rchk("R5", 0, 8'h44, 8'h17);
    chk("R5", {31'b0, pm_decode_en}, 32'h1); chk("R5", {28'b0, pm_irq}, 32'd9);
    wr(0, 8'h44, 8'h02);
    chk("R5", {31'b0, pm_decode_en}, 32'h0); chk("R5", {28'b0, pm_irq}, 32'd11);
    wr(0, 8'h44, 8'h11);
    chk("R5", {31'b0, pm_decode_en}, 32'h1); chk("R5", {28'b0, pm_irq}, 32'd10);
    wr(0, 8'h44, 8'h00); chk("R5", {28'b0, pm_irq}, 32'd9);
    wr(0, 8'h44, 8'h03); chk("R5", {28'b0, pm_irq}, 32'd9);
  endtask

  task automatic t_fw_lock;
    wr(0, 8'h4E, 8'hFD); rchk("R6", 0, 8'h4E, 8'h01);
    chk("R7", {31'b0, last_smi}, 32'h0);
    wr(0, 8'h4E, 8'h03); chk("R7", {31'b0, last_smi}, 32'h1);
    rchk("R6", 0, 8'h4E, 8'h03);
    chk("R7", {31'b0, smi_req}, 32'h0);
    wr(0, 8'h4E, 8'h00); rchk("R6", 0, 8'h4E, 8'h02);
    chk("R7", {31'b0, last_smi}, 32'h0);
    wr(0, 8'h4E, 8'h01); rchk("R6", 0, 8'h4E, 8'h03);
    chk("R7", {31'b0, last_smi}, 32'h1);
    wr(0, 8'h04, 8'h00); chk("R7", {31'b0, last_smi}, 32'h0);
  endtask

  task automatic t_functions;
    rchk("R9", 1, 8'h10, 8'h5A);
    wr(1, 8'h10, 8'h77); chk("R9", {31'b0, last_peer}, 32'h1);
    wr(0, 8'hF2, 8'hFF); rchk("R8", 0, 8'hF2, 8'hFE);
    rchk("R8", 1, 8'h10, 8'hFF); rchk("R8", 6, 8'h00, 8'hFF);
    wr(3, 8'h10, 8'h77); chk("R8", {31'b0, last_peer}, 32'h0);
    rchk("R8", 0, 8'h04, 8'h0F);
    wr(0, 8'hF2, 8'h08);
    rchk("R8", 3, 8'h20, 8'hFF); rchk("R9", 2, 8'h20, 8'h5A);
    wr(2, 8'h20, 8'h01); chk("R9", {31'b0, last_peer}, 32'h1);
    wr(0, 8'hF2, 8'h00); rchk("R9", 3, 8'h20, 8'h5A);
  endtask

  task automatic t_undefined;
    wr(0, 8'h80, 8'h55); rchk("R10", 0, 8'h80, 8'h00);
    wr(0, 8'h00, 8'hFF); rchk("R10", 0, 8'h00, 8'h2B);
    wr(0, 8'h05, 8'hFF); rchk("R10", 0, 8'h05, 8'h00);
  endtask

  task automatic t_reset_again;
    wr(0, 8'hF2, 8'h02);
    @(negedge clk); rst = 1'b1;
    @(negedge clk); rst = 1'b0;
    t_reset_state("R11");
  endtask

  initial begin
    fork
      begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset_state("R1");
        t_command;
        t_status;
        t_pm_base;
        t_pm_ctl;
        t_fw_lock;
        t_functions;
        t_undefined;
        t_reset_again;
      end
      begin
        repeat (20000) @(posedge clk);
        failures++; checks++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule